// File: doc/BRIEF.md
# Partitioned SIMD Lane Multiplier

This block multiplies two packed 128-bit operand vectors lane by lane. A size control splits each operand into 8-, 16- or 32-bit lanes, and lane i of the result is built only from lane i of each operand. The multiply is either an ordinary unsigned integer product or a carry-less product over GF(2), in which partial products are combined with XOR. The block has no flag outputs. It never reports carry, overflow, sign or zero status.

Two output layouts are available. In the normal layout each lane keeps the low half of its double-width product, so the result has the same lane width as the sources. In the widening layout only the low 64 bits of each source are read, and every lane's full double-width product fills a result lane twice as wide. Requests arrive with a valid/ready handshake. The block accepts one request per cycle and returns a registered result with its own valid flag two cycles later. Control combinations that are not supported raise an illegal flag and give a zero result.

Top module: `lanemul_top`

## Requirements
- R1: With `widen_en`=0 and `lane_sz` 00, 01 or 10 (8, 16 or 32-bit lanes), result lane i at bits [i*W +: W] equals the low W bits of the product of source lane i of `src_a` and `src_b`, for all 128/W lanes.
- R2: Lane operands are unsigned. For example, 8-bit lanes of 0xFF times 0xFF give a normal-layout lane of 0x01.
- R3: With `widen_en`=1, only `src_a[63:0]` and `src_b[63:0]` are used. The full 2W-bit product of source lane i is placed at result bits [i*2W +: 2W] for 64/W lanes. With 32-bit lanes, 0xFFFFFFFF squared gives 0xFFFFFFFE00000001 in each 64-bit half.
- R4: With `poly_en`=1 and 8-bit lanes, each lane product is carry-less. For example, 0x03 times 0x03 gives 0x05, and 0xFF times 0xFF gives 0x5555 in the widening layout.
- R5: `lane_sz`=11 is reserved. The result is returned with `out_illegal`=1 and `out_data`=0.
- R6: `poly_en`=1 with any `lane_sz` other than 00 returns `out_illegal`=1 and `out_data`=0.
- R7: `in_ready` is always high. A request accepted at one rising edge appears with `out_valid`=1 exactly two rising edges later. Back-to-back requests are accepted every cycle, and results come out in order.
- R8: While reset is asserted and after it is released, `out_valid`, `out_illegal` and `out_data` are all zero until a result arrives.
- R9: `out_illegal` is high only together with `out_valid`. It stays low for every legal control combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken (always high) |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| lane_sz | input | 2 | Lane width: 00=8, 01=16, 10=32, 11 reserved |
| poly_en | input | 1 | Carry-less product instead of integer product |
| widen_en | input | 1 | Double-width products from the low 64 source bits |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Result vector |
| out_illegal | output | 1 | Unsupported control combination, result zeroed |

## Verification
On every cycle the assertions check the pipeline timing from acceptance to result. They also check that the illegal flag is raised for the reserved size and for polynomial mode at widths other than 8 bits, and that an illegal result is zero and arrives with valid. Two arithmetic identities are checked each cycle as well: a zero second operand gives a zero result, and a carry-less multiply by one returns the first operand unchanged. Only the bench's scenarios can show that every lane's product is correct. This covers all-ones and zero operands, the widening placement while the upper source bits hold other data, and the cases where carry-less and integer results differ.

// File: rtl/lanemul_pkg.sv
package lanemul_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } lane_sz_e;

    localparam int NUM_SZ = 3;

    // Reserved width, or carry-less mode outside 8-bit lanes.
    function automatic logic ctrl_illegal(lane_sz_e sz, logic poly);
        return (sz == SZ_RSVD) || (poly && (sz != SZ_BYTE));
    endfunction

endpackage

// File: rtl/lanemul_lane.sv
module lanemul_lane #(
    parameter int LW      = 8,
    parameter bit POLY_OK = 1'b0
) (
    input  logic [LW-1:0]   op_a,
    input  logic [LW-1:0]   op_b,
    input  logic            poly,
    output logic [2*LW-1:0] prod
);
    localparam int PW = 2 * LW;

    logic [PW-1:0] int_prod;
    logic [PW-1:0] cl_prod;

    always_comb begin
        int_prod = {{LW{1'b0}}, op_a} * {{LW{1'b0}}, op_b};
    end

    generate
        if (POLY_OK) begin : g_clmul
            always_comb begin
                cl_prod = '0;
                for (int k = 0; k < LW; k++) begin
                    if (op_b[k]) cl_prod = cl_prod ^ ({{LW{1'b0}}, op_a} << k);
                end
            end
            assign prod = poly ? cl_prod : int_prod;
        end else begin : g_int_only
            logic unused_poly;
            assign unused_poly = poly;
            assign cl_prod     = '0;
            assign prod        = int_prod;
        end
    endgenerate

endmodule

// File: rtl/lanemul_array.sv
module lanemul_array #(
    parameter int VEC_W   = 128,
    parameter int LW      = 8,
    parameter bit POLY_OK = 1'b0
) (
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  logic             poly,
    output logic [VEC_W-1:0] norm_res,
    output logic [VEC_W-1:0] wide_res
);
    localparam int NL = VEC_W / LW;
    localparam int NW = NL / 2;

    generate
        for (genvar i = 0; i < NL; i++) begin : g_lane
            logic [2*LW-1:0] p;
            lanemul_lane #(.LW(LW), .POLY_OK(POLY_OK)) u_lane (
                .op_a (vec_a[i*LW +: LW]),
                .op_b (vec_b[i*LW +: LW]),
                .poly (poly),
                .prod (p)
            );
            assign norm_res[i*LW +: LW] = p[LW-1:0];
            // Lanes in the low half of the sources also feed the wide layout.
            if (i < NW) begin : g_wide
                assign wide_res[i*2*LW +: 2*LW] = p;
            end
        end
    endgenerate

endmodule

// File: rtl/lanemul_top.sv
module lanemul_top
    import lanemul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [1:0]       lane_sz,
    input  logic             poly_en,
    input  logic             widen_en,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data,
    output logic             out_illegal
);
    localparam int BYTES = VEC_W / 8;

    typedef struct packed {
        logic             s1_valid;
        logic [VEC_W-1:0] s1_a;
        logic [VEC_W-1:0] s1_b;
        lane_sz_e         s1_sz;
        logic             s1_poly;
        logic             s1_widen;
        logic             out_valid;
        logic [VEC_W-1:0] out_data;
        logic             out_illegal;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [VEC_W-1:0] norm_v [NUM_SZ];
    logic [VEC_W-1:0] wide_v [NUM_SZ];
    logic             s1_ill;
    logic [VEC_W-1:0] sel_res;

    generate
        for (genvar g = 0; g < NUM_SZ; g++) begin : g_width
            lanemul_array #(
                .VEC_W   (VEC_W),
                .LW      (8 << g),
                .POLY_OK (g == 0)
            ) u_arr (
                .vec_a    (st_q.s1_a),
                .vec_b    (st_q.s1_b),
                .poly     (st_q.s1_poly),
                .norm_res (norm_v[g]),
                .wide_res (wide_v[g])
            );
        end
    endgenerate

    assign in_ready = 1'b1;

    always_comb begin
        s1_ill  = ctrl_illegal(st_q.s1_sz, st_q.s1_poly);
        sel_res = '0;
        case (st_q.s1_sz)
            SZ_BYTE: sel_res = st_q.s1_widen ? wide_v[0] : norm_v[0];
            SZ_HALF: sel_res = st_q.s1_widen ? wide_v[1] : norm_v[1];
            SZ_WORD: sel_res = st_q.s1_widen ? wide_v[2] : norm_v[2];
            default: sel_res = '0;
        endcase

        st_d = st_q;
        // Stage 1: capture operands and controls.
        st_d.s1_valid = in_valid;
        if (in_valid) begin
            st_d.s1_a     = src_a;
            st_d.s1_b     = src_b;
            st_d.s1_sz    = lane_sz_e'(lane_sz);
            st_d.s1_poly  = poly_en;
            st_d.s1_widen = widen_en;
        end
        // Stage 2: multiply, select layout, register result.
        st_d.out_valid   = st_q.s1_valid;
        st_d.out_illegal = st_q.s1_valid && s1_ill;
        if (st_q.s1_valid) begin
            st_d.out_data = s1_ill ? '0 : sel_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.out_valid;
    assign out_data    = st_q.out_data;
    assign out_illegal = st_q.out_illegal;

    // R7: accepted request reaches stage 1 on the next edge
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> st_q.s1_valid);
    // R7: stage 1 is followed by the result one edge later
    p_out_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1_valid |=> out_valid);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.s1_valid |=> !out_valid);
    // R9: illegal flag only with a valid result
    p_ill_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid);
    // R5: illegal results are zero
    p_ill_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_data == '0));
    // R5: reserved size is flagged
    p_rsvd_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && st_q.s1_sz == SZ_RSVD) |=> out_illegal);
    // R6: carry-less outside 8-bit lanes is flagged
    p_poly_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && st_q.s1_poly && st_q.s1_sz != SZ_BYTE) |=> out_illegal);
    // R1: zero second operand gives a zero result
    p_zero_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && st_q.s1_sz != SZ_RSVD && !st_q.s1_poly && st_q.s1_b == '0)
        |=> (out_data == '0));
    // R4: carry-less multiply by one returns the first operand
    p_poly_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && st_q.s1_poly && st_q.s1_sz == SZ_BYTE && !st_q.s1_widen
         && st_q.s1_b == {BYTES{8'h01}})
        |=> (out_data == $past(st_q.s1_a)));

endmodule

// File: tb/sim_lanemul_top.sv
module sim_lanemul_top;

    typedef struct packed {
        logic [127:0] a;
        logic [127:0] b;
        logic [1:0]   sz;
        logic         poly;
        logic         widen;
        logic         ill;
    } vec_t;

    localparam logic [127:0] ONES = {128{1'b1}};
    localparam logic [127:0] ZERO = '0;
    localparam logic [127:0] PA   = 128'h0123456789ABCDEF_FEDCBA9876543210;
    localparam logic [127:0] PB   = 128'hDEADBEEF_CAFEF00D_13572468_9BDF0ACE;
    localparam logic [127:0] P03  = {16{8'h03}};
    localparam int NV = 14;

    localparam vec_t VEC [0:NV-1] = '{
        '{ONES, ONES, 2'd0, 1'b0, 1'b0, 1'b0},
        '{ONES, ONES, 2'd1, 1'b0, 1'b0, 1'b0},
        '{ONES, ONES, 2'd2, 1'b0, 1'b0, 1'b0},
        '{ZERO, PB,   2'd1, 1'b0, 1'b0, 1'b0},
        '{PA,   PB,   2'd0, 1'b0, 1'b1, 1'b0},
        '{ONES, ONES, 2'd2, 1'b0, 1'b1, 1'b0},
        '{P03,  P03,  2'd0, 1'b1, 1'b0, 1'b0},
        '{ONES, ONES, 2'd0, 1'b1, 1'b1, 1'b0},
        '{PA,   PB,   2'd3, 1'b0, 1'b0, 1'b1},
        '{PA,   PB,   2'd1, 1'b1, 1'b0, 1'b1},
        '{PA,   PB,   2'd1, 1'b0, 1'b0, 1'b0},
        '{PB,   PA,   2'd2, 1'b0, 1'b1, 1'b0},
        '{PA,   PB,   2'd0, 1'b1, 1'b0, 1'b0},
        '{PB,   ZERO, 2'd2, 1'b0, 1'b1, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [1:0]   lane_sz = '0;
    logic         poly_en = 1'b0;
    logic         widen_en = 1'b0;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_illegal;

    int nchk = 0;
    int nfail = 0;
    int pc = 0;
    int issued = 0;
    int rcvd = 0;
    logic [127:0] exp_d [0:NV-1];
    logic         exp_i [0:NV-1];
    int           iss_pc [0:NV-1];
    logic [127:0] obs_d [0:NV-1];

    always #2 clk = ~clk;
    always @(posedge clk) pc <= pc + 1;

    lanemul_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .lane_sz(lane_sz), .poly_en(poly_en),
        .widen_en(widen_en), .out_valid(out_valid), .out_data(out_data),
        .out_illegal(out_illegal)
    );

    function automatic logic [128:0] ref_mul(vec_t v);
        int w;
        int n;
        logic [63:0] m;
        logic [63:0] x;
        logic [63:0] y;
        logic [63:0] p;
        logic [127:0] r;
        if (v.sz == 2'd3 || (v.poly && v.sz != 2'd0)) return {1'b1, 128'h0};
        w = 8 << v.sz;
        n = v.widen ? 64 / w : 128 / w;
        m = (64'h1 << w) - 64'h1;
        r = '0;
        for (int l = 0; l < n; l++) begin
            x = 64'(v.a >> (l * w)) & m;
            y = 64'(v.b >> (l * w)) & m;
            if (v.poly) begin
                p = '0;
                for (int k = 0; k < w; k++) if (y[k]) p = p ^ (x << k);
            end else begin
                p = x * y;
            end
            if (v.widen) r = r | (128'(p) << (l * 2 * w));
            else         r = r | (128'(p & m) << (l * w));
        end
        return {1'b0, r};
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sampled at a falling edge, before the inputs are changed.
    task automatic observe();
        if (out_valid) begin
            if (rcvd >= issued) begin
                check("R7 extra result", 128'(rcvd), 128'(issued - 1));
            end else begin
                obs_d[rcvd] = out_data;
                check("R1/R3/R4 lane data", out_data, exp_d[rcvd]);
                check(exp_i[rcvd] ? "R5/R6 illegal flag" : "R9 illegal flag",
                      128'(out_illegal), 128'(exp_i[rcvd]));
                check("R7 latency", 128'(pc - iss_pc[rcvd]), 128'd2);
                rcvd++;
            end
        end else begin
            check("R9 flag without valid", 128'(out_illegal), 128'd0);
        end
    endtask

    task automatic run_all();
        logic [128:0] rr;
        // R8: reset state
        repeat (3) begin
            @(negedge clk);
            check("R8 valid in reset", 128'(out_valid), 128'd0);
            check("R8 data in reset", out_data, 128'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after release", {out_data[126:0], out_valid | out_illegal}, 128'd0);
        check("R7 ready", 128'(in_ready), 128'd1);
        // Vector table, back to back, with one idle gap after entry 5.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            observe();
            if (i == 6) begin
                in_valid = 1'b0;
                @(negedge clk);
                observe();
            end
            rr = ref_mul(VEC[i]);
            exp_d[i] = rr[127:0];
            exp_i[i] = rr[128];
            check("R5/R6 table flag", 128'(rr[128]), 128'(VEC[i].ill));
            iss_pc[i] = pc;
            issued++;
            in_valid = 1'b1;
            src_a = VEC[i].a;
            src_b = VEC[i].b;
            lane_sz = VEC[i].sz;
            poly_en = VEC[i].poly;
            widen_en = VEC[i].widen;
        end
        @(negedge clk);
        observe();
        in_valid = 1'b0;
        src_a = ONES;
        repeat (4) begin
            @(negedge clk);
            observe();
        end
        check("R7 result count", 128'(rcvd), 128'(NV));
        // Hand-computed corner values
        check("R2 all-ones byte", 128'(obs_d[0][7:0]), 128'h01);
        check("R2 all-ones word", 128'(obs_d[2][31:0]), 128'h1);
        check("R3 wide word square", 128'(obs_d[5][127:64]), 128'hFFFFFFFE00000001);
        check("R4 carry-less 3*3", 128'(obs_d[6][7:0]), 128'h05);
        check("R4 carry-less wide FF*FF", 128'(obs_d[7][15:0]), 128'h5555);
        check("R1 zero operand", obs_d[3], 128'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                nchk++;
                nfail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule